// File: doc/BRIEF.md
# Legacy NMI Status and Control Port

This block sits on a simple I/O read/write bus and gives software two byte-wide ports. The control port latches two error sources that can raise a non-maskable interrupt, a system-error pulse and a channel-check pulse. It also shows the live timer channel-2 output and a refresh toggle bit. Two of its bits gate the speaker and drive the timer channel-2 count enable. The mask port is write-only. It holds one global NMI mask bit and a 7-bit index that is driven continuously to the real-time-clock storage.

Each error status bit is sticky. It collects events only while its own enable-control bit is 0. Writing 1 to that control bit clears the status and keeps it clear. Writing 0 arms it again. The NMI request is the OR of both status bits, suppressed while the global mask is set. A status bit that latched while the mask was set raises the request as soon as the mask is released. Register updates take effect on the clock edge after a write. Reads are combinational.

Top module: `nmi_legacy_port`

## Requirements
- R1: After reset, a read of the control port returns 00h when the timer input is 0. `spkr_out`, `tmr2_gate`, `nmi_req` and `rtc_index` are all 0.
- R2: The control port sits at address 61h. Bits 3:0 are read/write and take the written value on the next clock. Written values of bits 7:4 are ignored.
- R3: Control bit 7 is the system-error status. A `serr_evt` pulse sets it on the next clock while control bit 2 is 0, and it then stays set.
- R4: Writing control bit 2 as 1 clears bit 7. While bit 2 stays 1, `serr_evt` pulses are ignored. Writing bit 2 back to 0 re-arms bit 7 from the following cycle.
- R5: Control bit 6 is the channel-check status. It is set by `chk_evt` while control bit 3 is 0. Writing bit 3 as 1 clears it and blocks it.
- R6: If an event arrives in the same cycle as a write that sets its enable-control bit, the clear wins and the status reads 0.
- R7: Control bit 5 reads the live level of `tmr2_out`.
- R8: Control bit 4 inverts on each clock in which `refresh_tick` is 1. It holds its value otherwise.
- R9: `spkr_out` is 0 while control bit 1 is 0. It equals `tmr2_out` while control bit 1 is 1.
- R10: `tmr2_gate` equals control bit 0.
- R11: The mask port sits at address 70h. Bit 7 of a write is the NMI mask and bits 6:0 appear on `rtc_index`. A write there leaves the control port unchanged. A read of 70h, or of any unmapped address, returns 00h.
- R12: `nmi_req` = (bit 7 OR bit 6) AND NOT mask. Status latched while masked is kept, and the request asserts once the mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read enable |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| serr_evt | input | 1 | System-error event pulse |
| chk_evt | input | 1 | Channel-check event pulse |
| tmr2_out | input | 1 | Timer channel-2 output level |
| refresh_tick | input | 1 | One-cycle refresh period tick |
| spkr_out | output | 1 | Gated speaker output |
| tmr2_gate | output | 1 | Timer channel-2 count enable |
| rtc_index | output | 7 | RTC/CMOS index |
| nmi_req | output | 1 | NMI request |

## Verification
The bench targets the collision of an event with the write that clears it. A design that lets the set win would show bit 7 or bit 6 as 1 right after the clearing write. It also covers re-arming with an event in the same cycle as the write of 0. There, a design that arms one cycle early would latch a status that should have been blocked. Writes with the read-only bits 7:4 set check that those bits are ignored, and a faulty design would report stale ones. Further checks cover an event captured while masked, which must raise the request once the mask is released, and a write or read at 70h, which must not disturb or leak the control byte.

// File: rtl/nmi_port_pkg.sv
package nmi_port_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_SRC = 2;   // 0: system error, 1: channel check
  localparam int CTL_BITS = 4;

  // Next value of a sticky status: blocking or clearing write wins over set
  function automatic logic sts_next(logic cur, logic evt, logic blk, logic wclr);
    if (blk || wclr) return 1'b0;
    return cur | evt;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctl_byte(logic serr_s, logic chk_s,
                                                      logic tmr, logic rf,
                                                      logic [CTL_BITS-1:0] ctl);
    return {serr_s, chk_s, tmr, rf, ctl};
  endfunction

  function automatic logic nmi_request(logic serr_s, logic chk_s, logic mask);
    return (serr_s | chk_s) & ~mask;
  endfunction
endpackage

// File: rtl/nmi_src_latch.sv
module nmi_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic blk,
  input  logic wclr,
  output logic sts
);
  import nmi_port_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) sts <= 1'b0;
    else        sts <= sts_next(sts, evt, blk, wclr);
  end

  p_set_on_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !blk && !wclr) |=> sts);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !blk && !wclr) |=> sts);
  p_blocked_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> !sts);
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wclr |=> !sts);
endmodule

// File: rtl/nmi_rfsh_toggle.sv
module nmi_rfsh_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= 1'b0;
    else if (tick) q <= ~q;
  end

  p_toggle_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (q != $past(q)));
  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(q));
endmodule

// File: rtl/nmi_cfg_regs.sv
module nmi_cfg_regs #(
  parameter int CTL_W = 4,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic             wr_msk,
  input  logic [IDX_W:0]   wdata,
  output logic [CTL_W-1:0] ctl,
  output logic             mask,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl  <= '0;
      mask <= 1'b0;
      idx  <= '0;
    end else begin
      if (wr_ctl) ctl <= wdata[CTL_W-1:0];
      if (wr_msk) begin
        mask <= wdata[IDX_W];
        idx  <= wdata[IDX_W-1:0];
      end
    end
  end

  p_ctl_written_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctl == $past(wdata[CTL_W-1:0])));
  p_ctl_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctl));
  p_idx_written_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_msk |=> (idx == $past(wdata[IDX_W-1:0]) && mask == $past(wdata[IDX_W])));
endmodule

// File: rtl/nmi_legacy_port.sv
module nmi_legacy_port #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CTL_PORT = 16'h0061,
  parameter logic [ADDR_W-1:0] MSK_PORT = 16'h0070
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              serr_evt,
  input  logic              chk_evt,
  input  logic              tmr2_out,
  input  logic              refresh_tick,
  output logic              spkr_out,
  output logic              tmr2_gate,
  output logic [6:0]        rtc_index,
  output logic              nmi_req
);
  import nmi_port_pkg::*;

  localparam int IDX_W   = DATA_W - 1;
  localparam int BLK_LSB = 2;   // control bits 2 and 3 block the two sources

  logic                wr_ctl, wr_msk, rd_ctl;
  logic [CTL_BITS-1:0] ctl;
  logic                mask;
  logic [NUM_SRC-1:0]  evt, blk, wclr, sts;
  logic                rf_q;

  assign wr_ctl = io_wr && (io_addr == CTL_PORT);
  assign wr_msk = io_wr && (io_addr == MSK_PORT);
  assign rd_ctl = io_rd && (io_addr == CTL_PORT);
  assign evt    = {chk_evt, serr_evt};

  nmi_cfg_regs #(.CTL_W(CTL_BITS), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_msk(wr_msk),
    .wdata(io_wdata), .ctl(ctl), .mask(mask), .idx(rtc_index)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign blk[i]  = ctl[BLK_LSB+i];
    assign wclr[i] = wr_ctl && io_wdata[BLK_LSB+i];
    nmi_src_latch u_lat (
      .clk(clk), .rst_n(rst_n), .evt(evt[i]), .blk(blk[i]),
      .wclr(wclr[i]), .sts(sts[i])
    );
  end

  nmi_rfsh_toggle u_rf (.clk(clk), .rst_n(rst_n), .tick(refresh_tick), .q(rf_q));

  assign io_rdata  = rd_ctl ? pack_ctl_byte(sts[0], sts[1], tmr2_out, rf_q, ctl) : '0;
  assign spkr_out  = tmr2_out & ctl[1];
  assign tmr2_gate = ctl[0];
  assign nmi_req   = nmi_request(sts[0], sts[1], mask);

  p_spkr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !io_wdata[1]) |=> !spkr_out);
  p_gate_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (tmr2_gate == $past(io_wdata[0])));
  p_mask_silences_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msk && io_wdata[7]) |=> !nmi_req);
  p_msk_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == MSK_PORT) |-> (io_rdata == 8'h00));
endmodule

// File: tb/nmi_legacy_port_test.sv
module nmi_legacy_port_test;
  localparam time CYC = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        serr_evt = 1'b0, chk_evt = 1'b0, tmr2_out = 1'b0, refresh_tick = 1'b0;
  logic        spkr_out, tmr2_gate, nmi_req;
  logic [6:0]  rtc_index;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic rf_exp = 1'b0;

  always #(CYC/2) clk = ~clk;

  nmi_legacy_port uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .serr_evt(serr_evt), .chk_evt(chk_evt),
    .tmr2_out(tmr2_out), .refresh_tick(refresh_tick), .spkr_out(spkr_out),
    .tmr2_gate(tmr2_gate), .rtc_index(rtc_index), .nmi_req(nmi_req)
  );

  // vector: wr | addr[15:0] | wdata[7:0] | serr | chk | tmr | exp61[7:0] | expnmi
  localparam int NV = 15;
  localparam logic [36:0] VEC [0:NV-1] = '{
    {1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}, // idle
    {1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80, 1'b1}, // R3 set
    {1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h80, 1'b1}, // R3 sticky
    {1'b1, 16'h0061, 8'h04, 1'b0, 1'b0, 1'b0, 8'h04, 1'b0}, // R4 clear
    {1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h04, 1'b0}, // R4 blocked
    {1'b1, 16'h0061, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}, // R4 re-arm
    {1'b0, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h40, 1'b1}, // R5 set
    {1'b1, 16'h0061, 8'hF8, 1'b0, 1'b0, 1'b0, 8'h08, 1'b0}, // R2 R5 ro bits, clear
    {1'b1, 16'h0061, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // R5 still blocked this cycle
    {1'b0, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h40, 1'b1}, // R5 re-armed
    {1'b1, 16'h0061, 8'h08, 1'b0, 1'b1, 1'b0, 8'h08, 1'b0}, // R6 clear wins
    {1'b1, 16'h0061, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80, 1'b1}, // R3 with write of 0
    {1'b1, 16'h0061, 8'h03, 1'b0, 1'b0, 1'b1, 8'hA3, 1'b1}, // R2 R7
    {1'b1, 16'h0061, 8'h04, 1'b1, 1'b0, 1'b1, 8'h24, 1'b0}, // R6 serr vs clear
    {1'b1, 16'h0061, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}  // back to idle
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // apply one cycle of stimulus, then return to idle and read the control port
  task automatic step(logic wr, logic [15:0] a, logic [7:0] d, logic s, logic c, logic tick);
    io_wr = wr; io_addr = a; io_wdata = d; io_rd = 1'b0;
    serr_evt = s; chk_evt = c; refresh_tick = tick;
    @(posedge clk); @(negedge clk);
    io_wr = 1'b0; serr_evt = 1'b0; chk_evt = 1'b0; refresh_tick = 1'b0;
    io_rd = 1'b1; io_addr = 16'h0061;
    #1;
  endtask

  initial begin
    #(CYC * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    io_rd = 1'b1; io_addr = 16'h0061;
    #1;
    check("R1 rdata", io_rdata, 8'h00);
    check("R1 outputs", {4'b0, spkr_out, tmr2_gate, nmi_req, 1'b0}, 8'h00);
    check("R1 rtc_index", {1'b0, rtc_index}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      tmr2_out = VEC[i][9];
      step(VEC[i][36], VEC[i][35:20], VEC[i][19:12], VEC[i][11], VEC[i][10], 1'b0);
      check($sformatf("R2-R7 vector %0d rdata", i), io_rdata, VEC[i][8:1]);
      check($sformatf("R12 vector %0d nmi_req", i), {7'b0, nmi_req}, {7'b0, VEC[i][0]});
    end

    // R8 refresh toggle
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b1);
      rf_exp = ~rf_exp;
      check("R8 toggle on tick", io_rdata, {3'b000, rf_exp, 4'h0});
      step(1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0);
      check("R8 hold without tick", io_rdata, {3'b000, rf_exp, 4'h0});
    end

    // R9 speaker gate, R10 count enable
    tmr2_out = 1'b1;
    step(1'b1, 16'h0061, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R9 gated off", {7'b0, spkr_out}, 8'h00);
    step(1'b1, 16'h0061, 8'h02, 1'b0, 1'b0, 1'b0);
    check("R9 follows tmr high", {7'b0, spkr_out}, 8'h01);
    tmr2_out = 1'b0; #1;
    check("R9 follows tmr low", {7'b0, spkr_out}, 8'h00);
    check("R10 gate off", {7'b0, tmr2_gate}, 8'h00);
    step(1'b1, 16'h0061, 8'h01, 1'b0, 1'b0, 1'b0);
    check("R10 gate on", {7'b0, tmr2_gate}, 8'h01);

    // R11 mask port
    step(1'b1, 16'h0070, 8'h85, 1'b0, 1'b0, 1'b0);
    check("R11 rtc_index", {1'b0, rtc_index}, 8'h05);
    check("R11 ctl unchanged", io_rdata, {3'b000, rf_exp, 4'h1});
    io_addr = 16'h0070; #1;
    check("R11 read 70h", io_rdata, 8'h00);
    io_addr = 16'h0062; #1;
    check("R11 unmapped read", io_rdata, 8'h00);

    // R12 event captured while masked, request after unmask
    step(1'b0, 16'h0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R12 status while masked", io_rdata, {3'b100, rf_exp, 4'h1});
    check("R12 masked request", {7'b0, nmi_req}, 8'h00);
    step(1'b1, 16'h0070, 8'h05, 1'b0, 1'b0, 1'b0);
    check("R12 request after unmask", {7'b0, nmi_req}, 8'h01);

    finish_run();
  end
endmodule